// File: doc/BRIEF.md
# Interrupt Vector Register Block

The block collects sixteen level-sensitive interrupt request lines into a status vector, one clock behind the pins, and gates them with a sixteen-bit enable mask. Any source that is both requesting and enabled is pending. A single combined interrupt output goes high while anything is pending. Software reads a vector code that names the lowest-numbered pending source and sets the mask through a small register window.

The window holds two native sixteen-bit registers: the vector code at offset 0 (read-only) and the enable mask at offset 2. The window is decoded on a twelve-bit address. Bus requests can be 8, 16 or 32 bits wide. An access sequencer turns each request into one or two native sixteen-bit operations. A byte read selects one lane of the aligned register. A byte write reads the aligned register, merges the new byte and writes the full value back. A 32-bit access becomes a low half at the given address and a high half at the address plus 2.

The sequencer is a state machine with five states:
- `ST_IDLE` waits for a request.
- `ST_FIRST` performs the first or only native access.
- `ST_SECOND` performs the upper half of a 32-bit access.
- `ST_MERGE` writes back a merged byte.
- `ST_RESP` presents the response for one cycle.

The transitions are:
- IDLE to FIRST when a request is accepted.
- FIRST to SECOND for 32-bit accesses.
- FIRST to MERGE for byte writes.
- FIRST to RESP for all other accesses.
- SECOND to RESP, and MERGE to RESP.
- RESP to IDLE, always.

Top module: `irq_vector_regs`

## Requirements
- R1: Each status bit equals the level its request input had at the previous rising clock edge. A source is pending when its status bit and its mask bit are both 1.
- R2: A read at offset 0 returns (n+1) shifted left by 2, where n is the lowest-numbered pending source. It returns 0 when nothing is pending.
- R3: Offset 2 holds the 16-bit enable mask, which can be read and written.
- R4: `irq_out` is 1 exactly when at least one source is pending. A mask write changes it at the same edge that updates the mask, so the new level is visible when the write's response appears.
- R5: A byte read (size code 0) returns the aligned 16-bit register's low byte when address bit 0 is 0, and its high byte when address bit 0 is 1. The byte is zero-extended into `rsp_rdata`.
- R6: A byte write changes only the lane chosen by address bit 0 of the aligned register. The other lane keeps its previous value.
- R7: A 32-bit access (size code 2) operates on the address and on the address plus 2 (modulo 2^12). The first half maps to data bits 15:0 and the second half to bits 31:16, for both reads and writes.
- R8: Every offset other than 0 and 2 reads as 0, and writes to it are ignored. Writes to offset 0 are ignored. A 16-bit access uses its address unchanged.
- R9: The request/response handshake works as follows:
  - `req_ready` is high only when the block is idle.
  - Each accepted request produces exactly one single-cycle `rsp_valid` pulse.
  - For 16-bit accesses and byte reads, the pulse comes 2 cycles after acceptance. For 32-bit accesses and byte writes, it comes 3 cycles after acceptance.
  - Write responses carry 0 in `rsp_rdata`.
- R10: While reset is active and just after it:
  - the mask and status are 0;
  - `irq_out` and `rsp_valid` are 0;
  - `req_ready` is 1.
- R11: Size code 3 is treated as a 16-bit access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 16 | Level interrupt request lines |
| req_valid | input | 1 | Bus request present |
| req_ready | output | 1 | Block can accept a request (idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 16-bit |
| req_addr | input | 12 | Byte address within the window |
| req_wdata | input | 32 | Write data, low bits first |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| irq_out | output | 1 | Combined interrupt |

## Verification
The hardest case to reach from the ports is a byte write whose merge must keep the untouched lane, combined with a mask change that must move `irq_out` at the very edge the write lands. The stimulus first loads the mask with a known pattern, with a high-numbered source requesting. It then rewrites each lane separately, so that mask bit 15 only becomes set through the upper-lane merge. Each intermediate value is read back as a whole word and through the byte lanes. The stimulus also issues 32-bit accesses that straddle a defined and an undefined offset, and a byte write aimed at the read-only vector register, to show that only the mask half is taken.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FIRST,
        ST_SECOND,
        ST_MERGE,
        ST_RESP
    } ivr_state_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_ALT  = 2'd3
    } ivr_size_e;

    localparam int OFF_VECTOR = 0;
    localparam int OFF_MASK   = 2;
endpackage

// File: rtl/ivr_status.sv
module ivr_status #(
    parameter int NUM_SRC   = 16,
    parameter int REG_W     = 16,
    parameter int VEC_SHIFT = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic [REG_W-1:0]   mask,
    output logic               irq_any,
    output logic [REG_W-1:0]   vec_code
);
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic [NUM_SRC-1:0] status_q;
    logic [NUM_SRC-1:0] pend;
    logic [IDX_W-1:0]   low_idx;
    logic               found;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= irq_req;
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_pend
        assign pend[g] = status_q[g] & mask[g];
    end

    always_comb begin
        low_idx = '0;
        found   = 1'b0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend[i]) begin
                low_idx = IDX_W'(i);
                found   = 1'b1;
            end
        end
    end

    assign irq_any  = |pend;
    assign vec_code = found ? REG_W'((32'(low_idx) + 32'd1) << VEC_SHIFT) : '0;

    // R1
    status_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> status_q == $past(irq_req));
endmodule

// File: rtl/ivr_regfile.sv
module ivr_regfile #(
    parameter int ADDR_W = 12,
    parameter int REG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_we,
    input  logic [REG_W-1:0]  acc_wdata,
    input  logic [REG_W-1:0]  vec_code,
    output logic [REG_W-1:0]  acc_rdata,
    output logic [REG_W-1:0]  mask
);
    import ivr_pkg::*;

    logic [REG_W-1:0] mask_q;
    logic             hit_vec;
    logic             hit_mask;

    assign hit_vec  = (acc_addr == ADDR_W'(OFF_VECTOR));
    assign hit_mask = (acc_addr == ADDR_W'(OFF_MASK));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 mask_q <= '0;
        else if (acc_we && hit_mask) mask_q <= acc_wdata;
    end

    always_comb begin
        if (hit_vec)       acc_rdata = vec_code;
        else if (hit_mask) acc_rdata = mask_q;
        else               acc_rdata = '0;
    end

    assign mask = mask_q;

    // R8
    mask_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mask_q) |-> $past(acc_we && acc_addr == ADDR_W'(OFF_MASK)));
endmodule

// File: rtl/ivr_access_fsm.sv
module ivr_access_fsm #(
    parameter int ADDR_W = 12,
    parameter int REG_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [1:0]          req_size,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [2*REG_W-1:0]  req_wdata,
    output logic                rsp_valid,
    output logic [2*REG_W-1:0]  rsp_rdata,
    output logic [ADDR_W-1:0]   acc_addr,
    output logic                acc_we,
    output logic [REG_W-1:0]    acc_wdata,
    input  logic [REG_W-1:0]    acc_rdata
);
    import ivr_pkg::*;

    localparam int DATA_W = 2 * REG_W;
    localparam int LANE_W = REG_W / 2;

    ivr_state_e state_q, state_d;

    logic              op_write;
    ivr_size_e         op_size;
    logic [ADDR_W-1:0] op_addr;
    logic [DATA_W-1:0] op_wdata;
    logic [REG_W-1:0]  lo_q;
    logic [REG_W-1:0]  hi_q;

    logic [ADDR_W-1:0] aligned_addr;
    logic [ADDR_W-1:0] upper_addr;
    logic [REG_W-1:0]  merged;
    logic [DATA_W-1:0] read_result;

    assign aligned_addr = {op_addr[ADDR_W-1:1], 1'b0};
    assign upper_addr   = op_addr + ADDR_W'(2);
    assign merged = op_addr[0] ? {op_wdata[LANE_W-1:0], lo_q[LANE_W-1:0]}
                               : {lo_q[REG_W-1:LANE_W], op_wdata[LANE_W-1:0]};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_FIRST;
            ST_FIRST: begin
                if (op_size == SZ_WORD)                   state_d = ST_SECOND;
                else if (op_size == SZ_BYTE && op_write)  state_d = ST_MERGE;
                else                                      state_d = ST_RESP;
            end
            ST_SECOND: state_d = ST_RESP;
            ST_MERGE:  state_d = ST_RESP;
            ST_RESP:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // request latch and read capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_write <= 1'b0;
            op_size  <= SZ_HALF;
            op_addr  <= '0;
            op_wdata <= '0;
            lo_q     <= '0;
            hi_q     <= '0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                op_write <= req_write;
                op_size  <= ivr_size_e'(req_size);
                op_addr  <= req_addr;
                op_wdata <= req_wdata;
                lo_q     <= '0;
                hi_q     <= '0;
            end
            if (state_q == ST_FIRST)  lo_q <= acc_rdata;
            if (state_q == ST_SECOND) hi_q <= acc_rdata;
        end
    end

    always_comb begin
        unique case (op_size)
            SZ_BYTE: read_result = op_addr[0] ? DATA_W'(lo_q[REG_W-1:LANE_W])
                                              : DATA_W'(lo_q[LANE_W-1:0]);
            SZ_WORD: read_result = {hi_q, lo_q};
            default: read_result = DATA_W'(lo_q);
        endcase
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        rsp_rdata = '0;
        acc_addr  = op_addr;
        acc_we    = 1'b0;
        acc_wdata = op_wdata[REG_W-1:0];
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_FIRST: begin
                acc_addr = (op_size == SZ_BYTE) ? aligned_addr : op_addr;
                acc_we   = op_write && (op_size != SZ_BYTE);
            end
            ST_SECOND: begin
                acc_addr  = upper_addr;
                acc_we    = op_write;
                acc_wdata = op_wdata[DATA_W-1:REG_W];
            end
            ST_MERGE: begin
                acc_addr  = aligned_addr;
                acc_we    = 1'b1;
                acc_wdata = merged;
            end
            ST_RESP: begin
                rsp_valid = 1'b1;
                rsp_rdata = op_write ? '0 : read_result;
            end
            default: ;
        endcase
    end

    // R9
    resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R9
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    // R9
    write_rsp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && op_write) |-> rsp_rdata == '0);
endmodule

// File: rtl/irq_vector_regs.sv
module irq_vector_regs #(
    parameter int NUM_SRC   = 16,
    parameter int ADDR_W    = 12,
    parameter int REG_W     = 16,
    parameter int VEC_SHIFT = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [1:0]         req_size,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [2*REG_W-1:0] req_wdata,
    output logic               rsp_valid,
    output logic [2*REG_W-1:0] rsp_rdata,
    output logic               irq_out
);
    logic [ADDR_W-1:0] acc_addr;
    logic              acc_we;
    logic [REG_W-1:0]  acc_wdata;
    logic [REG_W-1:0]  acc_rdata;
    logic [REG_W-1:0]  mask;
    logic [REG_W-1:0]  vec_code;

    ivr_access_fsm #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_size  (req_size),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .acc_addr  (acc_addr),
        .acc_we    (acc_we),
        .acc_wdata (acc_wdata),
        .acc_rdata (acc_rdata)
    );

    ivr_regfile #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_addr  (acc_addr),
        .acc_we    (acc_we),
        .acc_wdata (acc_wdata),
        .vec_code  (vec_code),
        .acc_rdata (acc_rdata),
        .mask      (mask)
    );

    ivr_status #(.NUM_SRC(NUM_SRC), .REG_W(REG_W), .VEC_SHIFT(VEC_SHIFT)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_req  (irq_req),
        .mask     (mask),
        .irq_any  (irq_out),
        .vec_code (vec_code)
    );

    // R4
    irq_vec_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (vec_code != '0));
    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (!irq_out && !rsp_valid));
endmodule

// File: tb/irq_vector_regs_tb.sv
module irq_vector_regs_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_req = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd1;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_vector_regs dut_i (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq_out(irq_out)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on each response
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected response", rsp_rdata, 32'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rsp_rdata === e, t, rsp_rdata, e);
            end
        end
    end

    // driver
    task automatic access(input bit wr, input logic [1:0] sz, input logic [11:0] a,
                          input logic [31:0] wd, input logic [31:0] exp,
                          input int exp_lat, input string req);
        int lat;
        exp_q.push_back(exp);
        tag_q.push_back(req);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R9 busy after accept", 32'(req_ready), 32'h0);
        lat = 1;
        while (!rsp_valid && lat < 10) begin
            @(negedge clk);
            lat++;
        end
        check(lat == exp_lat, "R9 latency", 32'(lat), 32'(exp_lat));
    endtask

    task automatic rd(input logic [1:0] sz, input logic [11:0] a, input logic [31:0] exp,
                      input string req);
        access(1'b0, sz, a, 32'h0, exp, (sz == 2'd2) ? 3 : 2, req);
    endtask

    task automatic wr(input logic [1:0] sz, input logic [11:0] a, input logic [31:0] wd,
                      input string req);
        access(1'b1, sz, a, wd, 32'h0, (sz == 2'd2 || sz == 2'd0) ? 3 : 2, req);
    endtask

    task automatic set_irq(input logic [15:0] v);
        @(negedge clk);
        irq_req = v;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%h expected=%h", 32'h1, 32'h0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check(irq_out == 1'b0, "R10 irq_out in reset", 32'(irq_out), 32'h0);
        check(rsp_valid == 1'b0, "R10 rsp_valid in reset", 32'(rsp_valid), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R10 ready after reset", 32'(req_ready), 32'h1);
        rd(2'd1, 12'h002, 32'h0, "R10 mask resets to zero");
        rd(2'd1, 12'h000, 32'h0, "R10 vector zero after reset");

        // R3 mask write and read back
        wr(2'd1, 12'h002, 32'h0000_FFFF, "R3 write mask");
        rd(2'd1, 12'h002, 32'h0000_FFFF, "R3 mask readback");
        rd(2'd1, 12'h000, 32'h0, "R2 nothing pending");

        // R1 status one cycle behind request
        @(negedge clk);
        irq_req = 16'h0020;
        #1;
        check(irq_out == 1'b0, "R1 not before edge", 32'(irq_out), 32'h0);
        @(negedge clk);
        check(irq_out == 1'b1, "R1 status follows request", 32'(irq_out), 32'h1);
        rd(2'd1, 12'h000, 32'h18, "R2 source 5 vector");
        set_irq(16'h8020);
        rd(2'd1, 12'h000, 32'h18, "R2 lowest wins");
        set_irq(16'h8000);
        rd(2'd1, 12'h000, 32'h40, "R2 source 15 vector");

        // R4 mask write updates irq_out with the write
        wr(2'd1, 12'h002, 32'h0000_7FFF, "R4 mask off bit 15");
        check(irq_out == 1'b0, "R4 irq drops with mask write", 32'(irq_out), 32'h0);
        rd(2'd1, 12'h000, 32'h0, "R2 masked source not pending");

        // R6 byte merge
        wr(2'd0, 12'h003, 32'h0000_00A5, "R6 high lane write");
        rd(2'd1, 12'h002, 32'h0000_A5FF, "R6 low lane kept");
        check(irq_out == 1'b1, "R4 irq rises via merged byte", 32'(irq_out), 32'h1);
        wr(2'd0, 12'h002, 32'h0000_003C, "R6 low lane write");
        rd(2'd1, 12'h002, 32'h0000_A53C, "R6 high lane kept");

        // R5 byte reads
        rd(2'd0, 12'h003, 32'h0000_00A5, "R5 high byte");
        rd(2'd0, 12'h002, 32'h0000_003C, "R5 low byte");
        rd(2'd0, 12'h000, 32'h0000_0040, "R5 vector low byte");
        rd(2'd0, 12'h001, 32'h0000_0000, "R5 vector high byte");

        // R7 32-bit split
        rd(2'd2, 12'h000, 32'hA53C_0040, "R7 word read halves");
        wr(2'd2, 12'h000, 32'h1234_5678, "R7 word write");
        rd(2'd1, 12'h002, 32'h0000_1234, "R7 upper half to mask");
        check(irq_out == 1'b0, "R4 irq low with new mask", 32'(irq_out), 32'h0);
        rd(2'd1, 12'h000, 32'h0, "R8 vector write ignored");

        // R8 undefined and read-only offsets
        wr(2'd0, 12'h001, 32'h0000_00FF, "R8 byte write to vector reg");
        rd(2'd1, 12'h002, 32'h0000_1234, "R8 mask unchanged after vector write");
        wr(2'd1, 12'h004, 32'h0000_FFFF, "R8 write undefined");
        rd(2'd1, 12'h004, 32'h0, "R8 undefined reads zero");
        rd(2'd1, 12'h002, 32'h0000_1234, "R8 mask unchanged after undefined write");
        rd(2'd1, 12'h100, 32'h0, "R8 far offset reads zero");
        rd(2'd1, 12'h003, 32'h0, "R8 odd 16-bit address undefined");
        rd(2'd2, 12'h002, 32'h0000_1234, "R7 word read straddling undefined");
        rd(2'd2, 12'hFFE, 32'h0000_0000, "R7 word read wraps to offset 0");

        // R11 size code 3
        set_irq(16'h0014);
        rd(2'd1, 12'h000, 32'h0C, "R2 source 2 vector");
        rd(2'd3, 12'h000, 32'h0C, "R11 alt size read");
        wr(2'd3, 12'h002, 32'hFFFF_0010, "R11 alt size write");
        rd(2'd1, 12'h002, 32'h0000_0010, "R11 only 16 bits written");
        rd(2'd1, 12'h000, 32'h14, "R2 source 4 vector");

        set_irq(16'h0000);
        check(irq_out == 1'b0, "R1 requests released", 32'(irq_out), 32'h0);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R9 all responses seen", 32'(exp_q.size()), 32'h0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule